// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block collects up to 32 level-high interrupt request lines and presents them to a processor as one combined interrupt line. Each request is captured into a per-source status bit. An enable register masks the status bits, and the result is a pending view. When more than one source is pending, the lowest-numbered one is reported as a source number through a read-only vector register. Software uses that number directly as its interrupt index.

Software reaches the block over a simple single-cycle register bus. The bus has a byte address, write data, read data, and separate read and write strobes. Enable bits can be replaced in one write. They can also be changed one bit at a time through a set alias and a clear alias, so a driver can mask or unmask one source without a read-modify-write. Writing ones to the acknowledge register retires captured requests. A two-bit master control gates two things: the processor output (bit 0) and the capture of hardware request lines (bit 1). While hardware capture is off, software may inject requests by writing the status register.

Top module: `irqc_top`

## Requirements
- R1: After reset, the following registers read zero: status, pending, enable, acknowledge, both aliases and master control. The vector register reads all ones, and `irq_out` is low.
- R2: While master bit 1 is 1, a high request line sets its status bit at the next clock edge. While master bit 1 is 0, request lines have no effect on status.
- R3: A write to the status register (offset 0) ORs the written ones into status only while master bit 1 is 0. While master bit 1 is 1, such a write is ignored.
- R4: A write to the acknowledge register (offset 12) clears each status bit whose written bit is 1. A source whose line is still high is captured again at the same edge, so its status bit stays set.
- R5: A write to the enable register (offset 8) replaces all enable bits. Writing 0 disables every source.
- R6: A write to the set-enable alias (offset 16) sets each enable bit whose written bit is 1 and leaves the other enable bits unchanged.
- R7: A write to the clear-enable alias (offset 20) clears each enable bit whose written bit is 1 and leaves the other enable bits unchanged.
- R8: The pending register (offset 4) reads status AND enable. Writes to it are ignored.
- R9: The vector register (offset 24) reads the index of the lowest set pending bit, zero-extended. It reads 0xFFFFFFFF when nothing is pending, and writes to it are ignored.
- R10: `irq_out` is registered. It is 1 exactly one cycle after a cycle in which master bit 0 (offset 28) is 1 and any pending bit is set.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and reflects the register values before that edge. Any access whose address is misaligned or beyond offset 28 is ignored, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Registered read data |
| irq_src | input | NSRC | Level-high interrupt request lines |
| irq_out | output | 1 | Registered combined interrupt to the processor |

## Verification
The bench builds the block with its defaults: 32 sources on a 32-bit bus with a 5-bit address. This puts source 31 into the top bit of every register, so the vector's boundary values are reachable: index 31, index 0 and the all-ones no-pending code. A vector table pairs request patterns with enable masks, including masks that hide every request and masks that leave only the highest source. The table confirms that the encoder picks the lowest survivor and not the lowest request. Directed steps cover the following:
- capture with hardware capture disabled and enabled;
- software injection;
- acknowledge of a line that is still held high;
- the enable aliases;
- the gating of the output by master bit 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register select = byte offset / 4; the ordering is the software map.
  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VECTOR = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;

  localparam int SEL_W = 3;
  localparam int MASTER_W = 2;
  localparam int MASTER_IRQ_BIT = 0;
  localparam int MASTER_HW_BIT = 1;
endpackage

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic            hw_en,
  input  logic            sw_we,
  input  logic [NSRC-1:0] sw_data,
  input  logic            ack_we,
  input  logic [NSRC-1:0] ack_data,
  output logic [NSRC-1:0] status_q
);
  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    logic keep, cap, inj;
    always_comb begin
      keep = status_q[g] & ~(ack_we & ack_data[g]);
      cap  = hw_en & src[g];
      inj  = sw_we & ~hw_en & sw_data[g];
    end
    always_ff @(posedge clk) begin
      if (rst) status_q[g] <= 1'b0;
      else     status_q[g] <= keep | cap | inj;
    end
  end

  // R2: every line seen high with capture on is latched next cycle
  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    hw_en |=> ((status_q & $past(src)) == $past(src)));

  // R2: with capture off and no software write, no new bit appears
  assert_no_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!hw_en && !sw_we) |=> ((status_q & ~$past(status_q)) == '0));

  // R4: acknowledged bits clear when capture cannot refill them
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (ack_we && !hw_en) |=> ((status_q & $past(ack_data)) == '0));
endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
  parameter int NSRC  = 32,
  parameter int IDX_W = 5
) (
  input  logic [NSRC-1:0]  pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   irq_src,
  output logic              irq_out
);
  import irqc_pkg::*;

  localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int BYTE_LSB = $clog2(DATA_W / 8);
  localparam int TOP_LSB  = BYTE_LSB + SEL_W;

  logic               aligned, in_range, hit;
  reg_sel_e           sel;
  logic [NSRC-1:0]    wd;
  logic               we_status, we_ack, we_enable, we_seten, we_clren, we_master;
  logic [NSRC-1:0]    status_q, enable_q, pend;
  logic [MASTER_W-1:0] master_q;
  logic               pend_any;
  logic [IDX_W-1:0]   pend_idx;
  logic [DATA_W-1:0]  vector_val, rd_mux;
  logic               irq_q;

  // Address decode
  always_comb begin
    aligned  = (bus_addr & ADDR_W'((1 << BYTE_LSB) - 1)) == '0;
    in_range = (bus_addr >> TOP_LSB) == '0;
    hit      = aligned & in_range;
    sel      = reg_sel_e'(bus_addr[BYTE_LSB +: SEL_W]);
    wd       = bus_wdata[NSRC-1:0];
    we_status = bus_wr & hit & (sel == SEL_STATUS);
    we_ack    = bus_wr & hit & (sel == SEL_ACK);
    we_enable = bus_wr & hit & (sel == SEL_ENABLE);
    we_seten  = bus_wr & hit & (sel == SEL_SETEN);
    we_clren  = bus_wr & hit & (sel == SEL_CLREN);
    we_master = bus_wr & hit & (sel == SEL_MASTER);
  end

  // Enable register with set/clear aliases
  always_ff @(posedge clk) begin
    if (rst)            enable_q <= '0;
    else if (we_enable) enable_q <= wd;
    else if (we_seten)  enable_q <= enable_q | wd;
    else if (we_clren)  enable_q <= enable_q & ~wd;
  end

  // Master control
  always_ff @(posedge clk) begin
    if (rst)            master_q <= '0;
    else if (we_master) master_q <= bus_wdata[MASTER_W-1:0];
  end

  irqc_status #(.NSRC(NSRC)) u_status (
    .clk      (clk),
    .rst      (rst),
    .src      (irq_src),
    .hw_en    (master_q[MASTER_HW_BIT]),
    .sw_we    (we_status),
    .sw_data  (wd),
    .ack_we   (we_ack),
    .ack_data (wd),
    .status_q (status_q)
  );

  assign pend = status_q & enable_q;

  irqc_lowest #(.NSRC(NSRC), .IDX_W(IDX_W)) u_lowest (
    .pend (pend),
    .any  (pend_any),
    .idx  (pend_idx)
  );

  assign vector_val = pend_any ? DATA_W'(pend_idx) : '1;

  // Registered read path
  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (sel)
        SEL_STATUS: rd_mux = DATA_W'(status_q);
        SEL_PEND:   rd_mux = DATA_W'(pend);
        SEL_ENABLE: rd_mux = DATA_W'(enable_q);
        SEL_VECTOR: rd_mux = vector_val;
        SEL_MASTER: rd_mux = DATA_W'(master_q);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  // Registered processor interrupt
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= master_q[MASTER_IRQ_BIT] & pend_any;
  end
  assign irq_out = irq_q;

  // R6: set alias leaves every written one set
  assert_set_alias_R6: assert property (@(posedge clk) disable iff (rst)
    we_seten |=> ((enable_q & $past(wd)) == $past(wd)));

  // R7: clear alias leaves every written one cleared
  assert_clr_alias_R7: assert property (@(posedge clk) disable iff (rst)
    we_clren |=> ((enable_q & $past(wd)) == '0));

  // R9: encoder result is a pending bit with none below it
  assert_vector_lowest_R9: assert property (@(posedge clk) disable iff (rst)
    pend_any |-> (pend[pend_idx] &&
                  ((pend & ((NSRC'(1) << pend_idx) - NSRC'(1))) == '0)));

  // R10: the output only rises with master bit 0 set the cycle before
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(master_q[MASTER_IRQ_BIT]) && $past(pend != '0)));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int NSRC = 32;
  localparam logic [4:0] A_STAT = 5'd0,  A_PEND = 5'd4,  A_EN  = 5'd8,
                         A_ACK  = 5'd12, A_SET  = 5'd16, A_CLR = 5'd20,
                         A_VEC  = 5'd24, A_MST  = 5'd28;

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [NSRC-1:0] irq_src = '0;
  logic        irq_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqc_top #(.NSRC(NSRC), .DATA_W(32), .ADDR_W(5)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_out(irq_out));

  // {request pattern, enable mask, expected vector}
  localparam logic [95:0] TABLE [8] = '{
    {32'h0000_0001, 32'hFFFF_FFFF, 32'd0},
    {32'h8000_0000, 32'hFFFF_FFFF, 32'd31},
    {32'h0000_0F00, 32'hFFFF_FFFF, 32'd8},
    {32'hF000_0000, 32'h3000_0000, 32'd28},
    {32'h0000_00FF, 32'h0000_00F0, 32'd4},
    {32'h0000_0005, 32'h0000_000A, 32'hFFFF_FFFF},
    {32'hFFFF_FFFF, 32'h0001_0000, 32'd16},
    {32'h8000_0001, 32'h8000_0000, 32'd31}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] s);
    @(negedge clk);
    irq_src = s;
    @(negedge clk);
    irq_src = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R11: reset values through every offset
    rd(A_STAT, d); check("R1 status", d, 32'h0);
    rd(A_PEND, d); check("R1 pending", d, 32'h0);
    rd(A_EN,   d); check("R1 enable", d, 32'h0);
    rd(A_ACK,  d); check("R1 ack", d, 32'h0);
    rd(A_SET,  d); check("R1 seten", d, 32'h0);
    rd(A_CLR,  d); check("R1 clren", d, 32'h0);
    rd(A_VEC,  d); check("R1 vector", d, 32'hFFFF_FFFF);
    rd(A_MST,  d); check("R1 master", d, 32'h0);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    rd(5'd26, d);  check("R11 misaligned read", d, 32'h0);

    // R2: capture off ignores request lines
    pulse(32'h0000_000F);
    rd(A_STAT, d); check("R2 no capture", d, 32'h0);

    // R3 / R4: software injection then partial acknowledge
    wr(A_STAT, 32'h0000_0030);
    rd(A_STAT, d); check("R3 inject", d, 32'h30);
    wr(A_ACK, 32'h0000_0010);
    rd(A_STAT, d); check("R4 partial ack", d, 32'h20);
    wr(A_ACK, 32'h0000_0020);

    // R10: output gated by master bit 0
    wr(A_EN, 32'hFFFF_FFFF);
    wr(A_STAT, 32'h0000_0004);
    @(negedge clk);
    check("R10 off while master bit0 low", {31'b0, irq_out}, 32'h0);
    wr(A_MST, 32'h1);
    @(negedge clk);
    check("R10 on", {31'b0, irq_out}, 32'h1);
    rd(A_VEC, d); check("R9 vector 2", d, 32'd2);
    wr(A_MST, 32'h0);
    @(negedge clk);
    check("R10 off again", {31'b0, irq_out}, 32'h0);
    wr(A_ACK, 32'hFFFF_FFFF);

    // R3: injection ignored once capture is on
    wr(A_MST, 32'h3);
    wr(A_STAT, 32'h0000_0001);
    rd(A_STAT, d); check("R3 inject ignored", d, 32'h0);

    // R2: capture on
    pulse(32'h0001_0000);
    rd(A_STAT, d); check("R2 capture", d, 32'h0001_0000);
    wr(A_ACK, 32'hFFFF_FFFF);

    // R4: a held line survives acknowledge
    @(negedge clk); irq_src = 32'h8;
    repeat (2) @(negedge clk);
    wr(A_ACK, 32'h8);
    rd(A_STAT, d); check("R4 held line recaptured", d, 32'h8);
    irq_src = '0;
    wr(A_ACK, 32'h8);
    rd(A_STAT, d); check("R4 cleared after release", d, 32'h0);

    // R5 / R6 / R7: enable writes
    wr(A_EN, 32'h1234_5678);
    rd(A_EN, d); check("R5 replace", d, 32'h1234_5678);
    wr(A_EN, 32'h0);
    rd(A_EN, d); check("R5 zero", d, 32'h0);
    wr(A_EN, 32'h0000_000F);
    wr(A_SET, 32'h0000_00F0);
    rd(A_EN, d); check("R6 set alias", d, 32'h0000_00FF);
    wr(A_CLR, 32'h0000_003C);
    rd(A_EN, d); check("R7 clear alias", d, 32'h0000_00C3);

    // R8 / R9: read-only registers ignore writes
    wr(A_EN, 32'h0000_00FF);
    pulse(32'h0000_0002);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); check("R8 pending write ignored", d, 32'h2);
    wr(A_VEC, 32'h0);
    rd(A_VEC, d); check("R9 vector write ignored", d, 32'd1);
    wr(A_ACK, 32'hFFFF_FFFF);
    wr(5'd30, 32'hFFFF_FFFF);
    rd(A_EN, d); check("R11 misaligned write ignored", d, 32'h0000_00FF);

    // R8 / R9 / R10: table of patterns
    for (int i = 0; i < 8; i++) begin
      logic [31:0] s, e, v;
      {s, e, v} = TABLE[i];
      wr(A_EN, e);
      pulse(s);
      rd(A_PEND, d); check("R8 table pending", d, s & e);
      rd(A_VEC, d);  check("R9 table vector", d, v);
      check("R10 table irq_out", {31'b0, irq_out}, {31'b0, (s & e) != 0});
      wr(A_ACK, 32'hFFFF_FFFF);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule